// File: doc/BRIEF.md
# Card-Detect and Shared Interrupt Aggregator

This block is the status and interrupt unit of a removable-card host interface. It samples two active-low card-detect pins through a two-flop synchronizer. It decodes whether a card is seated, which is the case only when both pins are low, and it records a card-detect event each time that decoded state changes. The data path of the interface reports seven more event pulses. Each event lands in a sticky local status bit, and software clears that bit by writing a one to it. A local enable mask decides which pending bits count as a request from this controller.

Requests are reported at two levels. The local request sets bit 0 of a global status register. A sibling controller's request line sets bit 1 of the same register. A per-bit global status-enable register and a single output signal-enable register are written separately, and together they gate the one shared interrupt output. Software reads the global register to learn which controller needs service, then handles that controller's local status and clears bits by writing back the value it read.

Top module: `cdirq_top`

## Requirements
- R1: A change of the decoded card presence, taken after the two-flop synchronizer, sets local status bit 0 (card detect). This holds for insertion and for removal. Local status is read at offset 0x04.
- R2: A card counts as present only when both detect pins are low. Pulling a single pin low while the card is absent causes no card-detect event.
- R3: The interface status register at offset 0x00 is read-only. Bit 0 is the pending status-change event (local status bit 1), bit 2 is synchronized detect pin 0, bit 3 is synchronized detect pin 1, bit 5 is card-ready and bit 6 is I/O-ready. All other bits read 0.
- R4: A local status bit sets on its event whatever the local enable mask (offset 0x08) holds.
- R5: Writing a 1 to a local status bit clears it. Writing a 0 leaves it unchanged.
- R6: When an event and a write-one-to-clear hit the same local bit in the same cycle, the bit stays set.
- R7: External event input bits map to local status bits 1 (status change), 2 (memory mode), 3 (I/O mode), 8 (IDE mode), 9 (transfer error), 10 (buffer available) and 11 (transfer done). External bits 0 and 4 to 7 are ignored, and local status bits 4 to 7 always read 0.
- R8: Global status bit 0 (offset 0x0C) sets in the cycle after any local status bit is pending together with its enable bit. It stays set until software writes a 1 to it.
- R9: Global status bit 1 sets when the sibling request input is high, and writing a 1 to it clears it.
- R10: The interrupt output is high exactly when some global status bit is set together with its bit in the global status-enable register (offset 0x10, bits 1:0) and the signal-enable register (offset 0x14, bit 0) is 1.
- R11: After reset, all status, enable and global registers read 0 and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| det_n | input | 2 | Card-detect pins, active low, asynchronous |
| card_ready | input | 1 | Card ready level from the card side |
| io_ready | input | 1 | I/O ready level from the card side |
| ext_evt | input | 12 | Single-cycle event pulses from the data path, one per local status position |
| sib_req | input | 1 | Interrupt request level from the sibling controller |
| reg_addr | input | 8 | Byte address of the register access |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq | output | 1 | Shared interrupt output |

## Verification
The embedded assertions check on every cycle that local status bits never drop without a clearing write, that an event always leaves its bit set one cycle later, and that written ones clear bits that had no coinciding event. They also check that the reserved status positions stay zero, that an enabled pending request reaches global bit 0, and that the interrupt output is never high without an enabled, set global bit. Some behaviour shows only in the bench scenarios: which pin combinations count as presence, the exact bit layout of the interface status register, the separate gating by status-enable and by signal-enable, and the clearing of the sibling's bit.

// File: rtl/cdirq_pkg.sv
package cdirq_pkg;
  localparam int DATA_W = 32;
  localparam int EVT_W  = 12;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_IFACE = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_LSTS  = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_LEN   = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_GSTS  = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_GEN   = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_SIGEN = 8'h14;

  localparam int BIT_CDET = 0;
  localparam int BIT_SCHG = 1;

  // positions the data path may set (card detect is internal)
  localparam logic [EVT_W-1:0] EXT_MASK = 12'hF0E;
  localparam logic [EVT_W-1:0] ALL_MASK = EXT_MASK | 12'h001;

  function automatic logic [EVT_W-1:0] f_sticky(input logic [EVT_W-1:0] cur,
                                                input logic [EVT_W-1:0] clr,
                                                input logic [EVT_W-1:0] set);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic f_present(input logic [1:0] pins_n);
    return (pins_n == 2'b00);
  endfunction

  function automatic logic [DATA_W-1:0] f_iface(input logic [1:0] pins_n,
                                                input logic schg,
                                                input logic rdy,
                                                input logic iordy);
    logic [DATA_W-1:0] v;
    v    = '0;
    v[0] = schg;
    v[2] = pins_n[0];
    v[3] = pins_n[1];
    v[5] = rdy;
    v[6] = iordy;
    return v;
  endfunction
endpackage

// File: rtl/cdirq_sync.sv
module cdirq_sync #(
  parameter int WIDTH = 2,
  parameter int STAGES = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_pin
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d_in[g]};
    end
    assign d_out[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/cdirq_detect.sv
module cdirq_detect
  import cdirq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] det_n,
  output logic [1:0] det_sync_n,
  output logic       present,
  output logic       cdet_evt
);
  logic present_q;

  cdirq_sync #(.WIDTH(2), .STAGES(2), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (det_n),
    .d_out (det_sync_n)
  );

  assign present = f_present(det_sync_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) present_q <= 1'b0;
    else        present_q <= present;
  end

  assign cdet_evt = present ^ present_q;

  AST_PRESENT_BOTH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    present |-> (det_sync_n[0] == 1'b0 && det_sync_n[1] == 1'b0)); // R2
endmodule

// File: rtl/cdirq_local.sv
module cdirq_local
  import cdirq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] evt,
  input  logic             sts_we,
  input  logic             len_we,
  input  logic [EVT_W-1:0] wdata,
  output logic [EVT_W-1:0] sts,
  output logic [EVT_W-1:0] len,
  output logic             loc_pend
);
  logic [EVT_W-1:0] clr_vec;
  logic [EVT_W-1:0] set_vec;

  assign clr_vec = sts_we ? wdata : '0;
  assign set_vec = evt & ALL_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts <= '0;
      len <= '0;
    end else begin
      sts <= f_sticky(sts, clr_vec, set_vec);
      if (len_we) len <= wdata & ALL_MASK;
    end
  end

  assign loc_pend = |(sts & len);

  AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt & ALL_MASK)) |=> ((sts & $past(evt & ALL_MASK)) == $past(evt & ALL_MASK))); // R4
  AST_NO_SILENT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !sts_we |=> ((sts & $past(sts)) == $past(sts))); // R5
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    sts_we |=> ((sts & $past(wdata & ~evt)) == '0)); // R6
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sts & ~ALL_MASK) == '0); // R7
endmodule

// File: rtl/cdirq_global.sv
module cdirq_global (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       loc_pend,
  input  logic       sib_req,
  input  logic       gsts_we,
  input  logic       gen_we,
  input  logic       sig_we,
  input  logic [1:0] wdata,
  output logic [1:0] gsts,
  output logic [1:0] gen,
  output logic       sig_en,
  output logic       irq
);
  logic [1:0] g_set;
  logic [1:0] g_clr;

  assign g_set = {sib_req, loc_pend};
  assign g_clr = gsts_we ? wdata : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gsts   <= 2'b00;
      gen    <= 2'b00;
      sig_en <= 1'b0;
    end else begin
      gsts <= (gsts & ~g_clr) | g_set;
      if (gen_we) gen <= wdata;
      if (sig_we) sig_en <= wdata[0];
    end
  end

  assign irq = sig_en & (|(gsts & gen));

  AST_LOCAL_REACHES_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
    loc_pend |=> gsts[0]); // R8
  AST_SIB_REACHES_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
    sib_req |=> gsts[1]); // R9
  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (sig_en && (gsts != 2'b00) && (gen != 2'b00))); // R10
endmodule

// File: rtl/cdirq_top.sv
module cdirq_top
  import cdirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        det_n,
  input  logic              card_ready,
  input  logic              io_ready,
  input  logic [EVT_W-1:0]  ext_evt,
  input  logic              sib_req,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  logic [1:0]       det_sync_n;
  logic             present;
  logic             cdet_evt;
  logic [EVT_W-1:0] evt_vec;
  logic [EVT_W-1:0] lsts;
  logic [EVT_W-1:0] len;
  logic             loc_pend;
  logic [1:0]       gsts;
  logic [1:0]       gen;
  logic             sig_en;
  logic             unused_wdata;
  logic             unused_present;

  assign unused_wdata   = ^reg_wdata[DATA_W-1:EVT_W];
  assign unused_present = present;

  cdirq_detect u_detect (
    .clk        (clk),
    .rst_n      (rst_n),
    .det_n      (det_n),
    .det_sync_n (det_sync_n),
    .present    (present),
    .cdet_evt   (cdet_evt)
  );

  always_comb begin
    evt_vec = ext_evt & EXT_MASK;
    evt_vec[BIT_CDET] = cdet_evt;
  end

  cdirq_local u_local (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt_vec),
    .sts_we   (reg_we && reg_addr == OFS_LSTS),
    .len_we   (reg_we && reg_addr == OFS_LEN),
    .wdata    (reg_wdata[EVT_W-1:0]),
    .sts      (lsts),
    .len      (len),
    .loc_pend (loc_pend)
  );

  cdirq_global u_global (
    .clk      (clk),
    .rst_n    (rst_n),
    .loc_pend (loc_pend),
    .sib_req  (sib_req),
    .gsts_we  (reg_we && reg_addr == OFS_GSTS),
    .gen_we   (reg_we && reg_addr == OFS_GEN),
    .sig_we   (reg_we && reg_addr == OFS_SIGEN),
    .wdata    (reg_wdata[1:0]),
    .gsts     (gsts),
    .gen      (gen),
    .sig_en   (sig_en),
    .irq      (irq)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_IFACE: reg_rdata = f_iface(det_sync_n, lsts[BIT_SCHG], card_ready, io_ready);
      OFS_LSTS:  reg_rdata[EVT_W-1:0] = lsts;
      OFS_LEN:   reg_rdata[EVT_W-1:0] = len;
      OFS_GSTS:  reg_rdata[1:0] = gsts;
      OFS_GEN:   reg_rdata[1:0] = gen;
      OFS_SIGEN: reg_rdata[0] = sig_en;
      default:   reg_rdata = '0;
    endcase
  end

  AST_CDET_ON_SYNC_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (det_sync_n == 2'b00) != ($past(det_sync_n) == 2'b00) |-> cdet_evt || !$past(rst_n)); // R1
endmodule

// File: tb/tb_cdirq_top.sv
module tb_cdirq_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  det_n = 2'b11;
  logic        card_ready = 1'b0;
  logic        io_ready = 1'b0;
  logic [11:0] ext_evt = '0;
  logic        sib_req = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // expected item: address (8'hFF selects the irq pin), value, tag
  logic [7:0]  q_addr[$];
  logic [31:0] q_val[$];
  string       q_tag[$];
  event        go;

  localparam logic [7:0] A_IF = 8'h00, A_LS = 8'h04, A_LE = 8'h08,
                         A_GS = 8'h0C, A_GE = 8'h10, A_SE = 8'h14, A_IRQ = 8'hFF;

  always #10 clk = ~clk;

  cdirq_top dut (
    .clk(clk), .rst_n(rst_n), .det_n(det_n), .card_ready(card_ready),
    .io_ready(io_ready), .ext_evt(ext_evt), .sib_req(sib_req),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  // monitor: pops expected items and compares
  initial begin
    forever begin
      @(go);
      #2;
      while (q_addr.size() > 0) begin
        logic [7:0]  a;
        logic [31:0] e, got;
        string       t;
        a = q_addr.pop_front();
        e = q_val.pop_front();
        t = q_tag.pop_front();
        got = (a == A_IRQ) ? {31'd0, irq} : reg_rdata;
        checks++;
        if (got !== e) begin
          errors++;
          $display("FAIL %s addr=%h actual=%h expected=%h", t, a, got, e);
        end
      end
    end
  end

  task automatic expect_val(input logic [7:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    if (a != A_IRQ) reg_addr = a;
    q_addr.push_back(a); q_val.push_back(e); q_tag.push_back(t);
    ->go;
    #4;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic pulse(input logic [11:0] v);
    @(negedge clk);
    ext_evt = v;
    @(negedge clk);
    ext_evt = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R11 reset state, R3 idle pins read high
    expect_val(A_LS, 32'h0, "R11 local status");
    expect_val(A_LE, 32'h0, "R11 local enable");
    expect_val(A_GS, 32'h0, "R11 global status");
    expect_val(A_GE, 32'h0, "R11 global enable");
    expect_val(A_SE, 32'h0, "R11 signal enable");
    expect_val(A_IRQ, 32'h0, "R11 irq low");
    expect_val(A_IF, 32'h0000000C, "R3 both pins high");

    // R2 one pin low: no presence change
    det_n = 2'b10;
    idle(6);
    expect_val(A_LS, 32'h0, "R2 single pin no event");
    expect_val(A_IF, 32'h00000008, "R3 pin0 low");

    // R1 insertion, R4 set with enable mask zero
    det_n = 2'b00;
    idle(6);
    expect_val(A_LS, 32'h1, "R1 insertion event");
    expect_val(A_GS, 32'h0, "R4 masked not global");

    // R5 write zero keeps, write one clears
    wr(A_LS, 32'h0);
    expect_val(A_LS, 32'h1, "R5 zero write no effect");
    wr(A_LS, 32'h1);
    expect_val(A_LS, 32'h0, "R5 write one clears");

    // R3 ready levels
    card_ready = 1'b1; io_ready = 1'b1;
    idle(1);
    expect_val(A_IF, 32'h00000060, "R3 ready bits");

    // R7 event mapping, reserved bits ignored
    pulse(12'hFFF);
    expect_val(A_LS, 32'h00000F0E, "R7 event positions");
    expect_val(A_IF, 32'h00000061, "R3 status change bit");
    wr(A_LS, 32'h00000F0E);
    expect_val(A_LS, 32'h0, "R5 write back clears");

    // R8 R10 enabled path
    wr(A_LE, 32'h400);
    wr(A_GE, 32'h1);
    wr(A_SE, 32'h1);
    pulse(12'h400);
    idle(1);
    expect_val(A_GS, 32'h1, "R8 global bit0 set");
    expect_val(A_IRQ, 32'h1, "R10 irq high");
    wr(A_LS, 32'h400);
    expect_val(A_GS, 32'h1, "R8 global sticky");
    wr(A_GS, 32'h1);
    expect_val(A_GS, 32'h0, "R8 global cleared");
    expect_val(A_IRQ, 32'h0, "R10 irq drops");

    // R6 event beats clear in same cycle
    @(negedge clk);
    reg_we = 1'b1; reg_addr = A_LS; reg_wdata = 32'h800; ext_evt = 12'h800;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0; ext_evt = '0;
    expect_val(A_LS, 32'h800, "R6 event wins");
    wr(A_LS, 32'h800);
    expect_val(A_LS, 32'h0, "R6 later clear");

    // R10 gating by signal enable and status enable
    pulse(12'h400);
    idle(1);
    wr(A_SE, 32'h0);
    expect_val(A_IRQ, 32'h0, "R10 signal enable off");
    wr(A_SE, 32'h1);
    expect_val(A_IRQ, 32'h1, "R10 signal enable on");
    wr(A_GE, 32'h0);
    expect_val(A_IRQ, 32'h0, "R10 status enable off");
    expect_val(A_GS, 32'h1, "R10 status kept");
    wr(A_LS, 32'h400);
    wr(A_GS, 32'h1);
    expect_val(A_GS, 32'h0, "R8 clear after gating");

    // R9 sibling
    wr(A_GE, 32'h1);
    @(negedge clk); sib_req = 1'b1;
    @(negedge clk); sib_req = 1'b0;
    expect_val(A_GS, 32'h2, "R9 sibling bit");
    expect_val(A_IRQ, 32'h0, "R10 sibling not enabled");
    wr(A_GE, 32'h3);
    expect_val(A_IRQ, 32'h1, "R10 sibling enabled");
    wr(A_GS, 32'h2);
    expect_val(A_GS, 32'h0, "R9 sibling cleared");
    expect_val(A_IRQ, 32'h0, "R9 irq after clear");

    // R1 removal
    det_n = 2'b11;
    idle(6);
    expect_val(A_LS, 32'h1, "R1 removal event");

    idle(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule